// File: doc/BRIEF.md
# TCM Access Protection Checker

This block checks each processor access aimed at the tightly coupled code and data memories against a bank of up to sixteen programmable protection regions. A region has a base address, a power-of-two size, eight sub-regions that can each be switched off, a 3-bit permission code and an execute-never bit. When several enabled regions cover the address, the one with the highest number decides. An optional background map allows privileged accesses that hit no region.

The allow decision is combinational in the request cycle. A denied access produces a one-cycle fault pulse on the next clock edge. The pulse carries the faulting address, the deciding region index and a flag that tells a region hit apart from a background miss. Accesses that do not target the tightly coupled memories are never checked. Accesses made in fault-handler context are not checked unless the control input asks for it. When the global enable is low, every access is allowed.

Top module: `tcm_prot_chk`

## Requirements
- R1: A write with `cfg_we_i` high loads every field of region `cfg_idx_i` at the clock edge. The new setting governs lookups from the next cycle on. All regions reset to disabled.
- R2: A region with size code `s` spans 2^(s+1) bytes, and its base is compared only on the bits at and above bit s+1. Codes 0 to 3 are invalid, and such a region never matches. Code 31 covers the whole address space.
- R3: When several enabled regions match, `hit_o` is high and `hit_idx_o` gives the highest matching region number. That region alone decides the permission.
- R4: A region is split into eight equal sub-regions, numbered by address bits [s:s-2]. Bit k of the region's sub-region mask set to 1 removes sub-region k from the region, so lower regions or the background map decide there.
- R5: Permission codes: 0 denies everything. 1 gives privileged read/write and nothing unprivileged. 2 gives privileged read/write and unprivileged read. 3 allows everything. 5 gives privileged read only. 6 gives read only to both. Codes 4 and 7 deny everything. A fetch counts as a read.
- R6: An instruction fetch (`req_fetch_i`=1) that hits a region whose execute-never bit is 1 is denied, whatever the permission code.
- R7: A checked access that hits no region is allowed only if `ctl_privdef_i` and `req_priv_i` are both 1.
- R8: An access with `req_hfctx_i`=1 is allowed without checking while `ctl_hfnmi_i`=0. It is checked normally while `ctl_hfnmi_i`=1.
- R9: An access with `req_tcm_i`=0, any access while `ctl_en_i`=0, and any cycle with `req_valid_i`=0 gives `allow_o`=1.
- R10: A valid, denied access gives `fault_o`=1 in the next cycle only. In that cycle `fault_addr_o`, `fault_idx_o` and `fault_hit_o` hold the access's address, its `hit_idx_o` and its `hit_o`. These three outputs hold their values between faults and reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Region write strobe |
| cfg_idx_i | input | 4 | Region number to write |
| cfg_en_i | input | 1 | Region enable |
| cfg_base_i | input | 32 | Region base address |
| cfg_size_i | input | 5 | Size code, span 2^(code+1) bytes |
| cfg_ap_i | input | 3 | Permission code |
| cfg_xn_i | input | 1 | Execute-never |
| cfg_srd_i | input | 8 | Sub-region disable mask, 1 = off |
| ctl_en_i | input | 1 | Global checking enable |
| ctl_hfnmi_i | input | 1 | Check in fault-handler context |
| ctl_privdef_i | input | 1 | Privileged background map |
| req_valid_i | input | 1 | Access present |
| req_addr_i | input | 32 | Access address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | Instruction fetch |
| req_priv_i | input | 1 | Privileged access |
| req_tcm_i | input | 1 | Access targets a tightly coupled memory |
| req_hfctx_i | input | 1 | Processor in hard-fault, NMI or fault-mask handler |
| allow_o | output | 1 | Access allowed (combinational) |
| hit_o | output | 1 | Some enabled region matches |
| hit_idx_o | output | 4 | Highest matching region |
| fault_o | output | 1 | Registered fault pulse |
| fault_addr_o | output | 32 | Address of last denied access |
| fault_idx_o | output | 4 | Region index of last denied access |
| fault_hit_o | output | 1 | Last denied access hit a region |

## Verification
A region write and an access to the same region can fall in the same cycle. In that cycle the access must still be judged against the old setting, and the new one applies only from the next cycle. The random phase mixes writes into the regions being accessed with back-to-back accesses, so such collisions happen often. The bench judges them with a reference model that updates its region table only after it has evaluated the access of that edge. A second collision is a fault pulse raised for one access while the next access is already being decided. Consecutive denied accesses are checked so that each pulse carries its own address and index.

// File: rtl/tcm_prot_pkg.sv
package tcm_prot_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned SZ_W    = 5;
  localparam int unsigned AP_W    = 3;
  localparam int unsigned NUM_SUB = 8;
  localparam int unsigned SUB_W   = $clog2(NUM_SUB);
  localparam int unsigned LG_W    = $clog2(ADDR_W + 1) + 1;
  localparam logic [SZ_W-1:0] MIN_SIZE = SZ_W'(4);

  localparam logic [AP_W-1:0] AP_NONE   = 3'd0;
  localparam logic [AP_W-1:0] AP_P_RW   = 3'd1;
  localparam logic [AP_W-1:0] AP_P_RW_U = 3'd2;
  localparam logic [AP_W-1:0] AP_FULL   = 3'd3;
  localparam logic [AP_W-1:0] AP_P_RO   = 3'd5;
  localparam logic [AP_W-1:0] AP_ALL_RO = 3'd6;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [SZ_W-1:0]   size;
    logic [AP_W-1:0]   ap;
    logic              xn;
    logic [NUM_SUB-1:0] srd;
  } rgn_cfg_t;

  function automatic logic ap_grants(logic [AP_W-1:0] ap, logic priv, logic wr);
    case (ap)
      AP_P_RW:   return priv;
      AP_P_RW_U: return priv | ~wr;
      AP_FULL:   return 1'b1;
      AP_P_RO:   return priv & ~wr;
      AP_ALL_RO: return ~wr;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tcm_prot_rgn_file.sv
module tcm_prot_rgn_file
  import tcm_prot_pkg::*;
#(
  parameter int unsigned NUM_RGN = 16,
  localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  rgn_cfg_t               wdata_i,
  output rgn_cfg_t [NUM_RGN-1:0] cfg_o
);
  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cfg_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))     cfg_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/tcm_prot_rgn_match.sv
module tcm_prot_rgn_match
  import tcm_prot_pkg::*;
(
  input  rgn_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [LG_W-1:0]   span_lg;
  logic [ADDR_W:0]   low_m;
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] shifted;
  logic [SUB_W-1:0]  sub;

  always_comb begin
    span_lg = LG_W'(cfg_i.size) + LG_W'(1);
    low_m   = ((ADDR_W+1)'(1) << span_lg) - (ADDR_W+1)'(1);
    diff    = (addr_i ^ cfg_i.base) & ~low_m[ADDR_W-1:0];
    // sub-region = three bits just under the span boundary
    shifted = addr_i >> (span_lg - LG_W'(SUB_W));
    sub     = shifted[SUB_W-1:0];
    hit_o   = cfg_i.en && (cfg_i.size >= MIN_SIZE) && (diff == '0) && !cfg_i.srd[sub];
  end
endmodule

// File: rtl/tcm_prot_decide.sv
module tcm_prot_decide
  import tcm_prot_pkg::*;
#(
  parameter int unsigned NUM_RGN = 16,
  localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
  input  logic [NUM_RGN-1:0]     hit_vec_i,
  input  rgn_cfg_t [NUM_RGN-1:0] cfg_i,
  input  logic                   ctl_en_i,
  input  logic                   ctl_hfnmi_i,
  input  logic                   ctl_privdef_i,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic                   req_fetch_i,
  input  logic                   req_priv_i,
  input  logic                   req_tcm_i,
  input  logic                   req_hfctx_i,
  output logic                   allow_o,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       hit_idx_o
);
  rgn_cfg_t sel;
  logic     bypass, perm_ok;

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    // ascending scan: last match is the highest number
    for (int i = 0; i < NUM_RGN; i++) begin
      if (hit_vec_i[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
    sel     = cfg_i[hit_idx_o];
    perm_ok = ap_grants(sel.ap, req_priv_i, req_write_i & ~req_fetch_i)
              & ~(req_fetch_i & sel.xn);
    bypass  = ~req_valid_i | ~req_tcm_i | ~ctl_en_i | (req_hfctx_i & ~ctl_hfnmi_i);
    allow_o = bypass | (hit_o ? perm_ok : (ctl_privdef_i & req_priv_i));
  end
endmodule

// File: rtl/tcm_prot_chk.sv
module tcm_prot_chk
  import tcm_prot_pkg::*;
#(
  parameter int unsigned NUM_RGN = 16,
  localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [ADDR_W-1:0]  cfg_base_i,
  input  logic [SZ_W-1:0]    cfg_size_i,
  input  logic [AP_W-1:0]    cfg_ap_i,
  input  logic               cfg_xn_i,
  input  logic [NUM_SUB-1:0] cfg_srd_i,
  input  logic               ctl_en_i,
  input  logic               ctl_hfnmi_i,
  input  logic               ctl_privdef_i,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_write_i,
  input  logic               req_fetch_i,
  input  logic               req_priv_i,
  input  logic               req_tcm_i,
  input  logic               req_hfctx_i,
  output logic               allow_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               fault_o,
  output logic [ADDR_W-1:0]  fault_addr_o,
  output logic [IDX_W-1:0]   fault_idx_o,
  output logic               fault_hit_o
);
  rgn_cfg_t                 wdata;
  rgn_cfg_t [NUM_RGN-1:0]   cfg;
  logic     [NUM_RGN-1:0]   hit_vec;
  logic                     deny;

  assign wdata = '{en: cfg_en_i, base: cfg_base_i, size: cfg_size_i,
                   ap: cfg_ap_i, xn: cfg_xn_i, srd: cfg_srd_i};

  tcm_prot_rgn_file #(.NUM_RGN(NUM_RGN)) u_file (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .idx_i(cfg_idx_i), .wdata_i(wdata), .cfg_o(cfg)
  );

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_match
    tcm_prot_rgn_match u_match (.cfg_i(cfg[g]), .addr_i(req_addr_i), .hit_o(hit_vec[g]));
  end

  tcm_prot_decide #(.NUM_RGN(NUM_RGN)) u_decide (
    .hit_vec_i(hit_vec), .cfg_i(cfg),
    .ctl_en_i, .ctl_hfnmi_i, .ctl_privdef_i,
    .req_valid_i, .req_write_i, .req_fetch_i, .req_priv_i, .req_tcm_i, .req_hfctx_i,
    .allow_o, .hit_o, .hit_idx_o
  );

  assign deny = req_valid_i & ~allow_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o      <= 1'b0;
      fault_addr_o <= '0;
      fault_idx_o  <= '0;
      fault_hit_o  <= 1'b0;
    end else begin
      fault_o <= deny;
      if (deny) begin
        fault_addr_o <= req_addr_i;
        fault_idx_o  <= hit_idx_o;
        fault_hit_o  <= hit_o;
      end
    end
  end
endmodule

// File: rtl/tcm_prot_sva.sv
module tcm_prot_sva #(
  parameter int unsigned NUM_RGN = 16,
  localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_en_i,
  input logic             ctl_hfnmi_i,
  input logic             ctl_privdef_i,
  input logic             req_valid_i,
  input logic [31:0]      req_addr_i,
  input logic             req_priv_i,
  input logic             req_tcm_i,
  input logic             req_hfctx_i,
  input logic             allow_o,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic             fault_o,
  input logic [31:0]      fault_addr_o,
  input logic [IDX_W-1:0] fault_idx_o
);
  // R9
  global_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_en_i |-> allow_o);
  // R9
  non_tcm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_tcm_i |-> allow_o);
  // R8
  handler_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_hfctx_i && !ctl_hfnmi_i) |-> allow_o);
  // R7
  background_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_tcm_i && ctl_en_i && !(req_hfctx_i && !ctl_hfnmi_i) && !hit_o)
      |-> (allow_o == (ctl_privdef_i && req_priv_i)));
  // R10
  fault_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !allow_o) |=> (fault_o && fault_addr_o == $past(req_addr_i)
                                   && fault_idx_o == $past(hit_idx_o)));
  // R10
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !allow_o) |=> !fault_o);
  // R10
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !allow_o) |=> $stable(fault_addr_o));
endmodule

bind tcm_prot_chk tcm_prot_sva #(.NUM_RGN(NUM_RGN)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_en_i(ctl_en_i), .ctl_hfnmi_i(ctl_hfnmi_i),
  .ctl_privdef_i(ctl_privdef_i), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_priv_i(req_priv_i), .req_tcm_i(req_tcm_i), .req_hfctx_i(req_hfctx_i),
  .allow_o(allow_o), .hit_o(hit_o), .hit_idx_o(hit_idx_o), .fault_o(fault_o),
  .fault_addr_o(fault_addr_o), .fault_idx_o(fault_idx_o)
);

// File: tb/sim_tcm_prot_chk.sv
module sim_tcm_prot_chk;
  localparam int CLK_T = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_xn = 0;
  logic [3:0] cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic [4:0] cfg_size = 0;
  logic [2:0] cfg_ap = 0;
  logic [7:0] cfg_srd = 0;
  logic ctl_en = 0, ctl_hfnmi = 0, ctl_privdef = 0;
  logic req_valid = 0, req_write = 0, req_fetch = 0, req_priv = 0, req_tcm = 0, req_hfctx = 0;
  logic [31:0] req_addr = 0;
  logic allow, hit, fault, fault_hit;
  logic [3:0] hit_idx, fault_idx;
  logic [31:0] fault_addr;

  always #(CLK_T/2) clk = ~clk;

  tcm_prot_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
    .cfg_base_i(cfg_base), .cfg_size_i(cfg_size), .cfg_ap_i(cfg_ap), .cfg_xn_i(cfg_xn),
    .cfg_srd_i(cfg_srd), .ctl_en_i(ctl_en), .ctl_hfnmi_i(ctl_hfnmi), .ctl_privdef_i(ctl_privdef),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_write_i(req_write),
    .req_fetch_i(req_fetch), .req_priv_i(req_priv), .req_tcm_i(req_tcm), .req_hfctx_i(req_hfctx),
    .allow_o(allow), .hit_o(hit), .hit_idx_o(hit_idx), .fault_o(fault),
    .fault_addr_o(fault_addr), .fault_idx_o(fault_idx), .fault_hit_o(fault_hit)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R10";

  // reference model state
  bit          m_en [16];
  logic [31:0] m_base [16];
  int          m_size [16];
  int          m_ap [16];
  bit          m_xn [16];
  logic [7:0]  m_srd [16];
  bit          e_fault, e_fhit;
  int          e_fidx;
  logic [31:0] e_faddr;

  task automatic check(string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic ref_eval(output bit al, output bit ht, output int ix);
    bit ok;
    ht = 0; ix = 0;
    for (int r = 15; r >= 0; r--) begin
      if (!ht && m_en[r] && m_size[r] >= 4) begin
        longint unsigned span = longint'(1) << (m_size[r] + 1);
        longint unsigned lo = (longint'(m_base[r]) / span) * span;
        longint unsigned a = longint'(req_addr);
        if (a >= lo && a < lo + span) begin
          int part = int'((a - lo) / (span / 8));
          if (!m_srd[r][part]) begin ht = 1; ix = r; end
        end
      end
    end
    if (!req_valid || !req_tcm || !ctl_en || (req_hfctx && !ctl_hfnmi)) al = 1;
    else if (!ht) al = ctl_privdef && req_priv;
    else if (req_fetch && m_xn[ix]) al = 0;
    else begin
      bit w = req_write && !req_fetch;
      case (m_ap[ix])
        1: ok = req_priv;
        2: ok = req_priv || !w;
        3: ok = 1;
        5: ok = req_priv && !w;
        6: ok = !w;
        default: ok = 0;
      endcase
      al = ok;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < 16; r++) begin
        m_en[r] = 0; m_base[r] = 0; m_size[r] = 0; m_ap[r] = 0; m_xn[r] = 0; m_srd[r] = 0;
      end
      e_fault = 0; e_fhit = 0; e_fidx = 0; e_faddr = 0;
    end else begin
      bit al, ht; int ix;
      ref_eval(al, ht, ix);
      e_fault = req_valid && !al;
      if (e_fault) begin e_fhit = ht; e_fidx = ix; e_faddr = req_addr; end
      if (cfg_we) begin
        m_en[cfg_idx] = cfg_en; m_base[cfg_idx] = cfg_base; m_size[cfg_idx] = cfg_size;
        m_ap[cfg_idx] = cfg_ap; m_xn[cfg_idx] = cfg_xn; m_srd[cfg_idx] = cfg_srd;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit al, ht; int ix;
      ref_eval(al, ht, ix);
      check("allow", allow, al);
      check("hit", hit, ht);
      if (ht) check("hit_idx", hit_idx, ix);
      check("fault", fault, e_fault);
      check("fault_addr", fault_addr, e_faddr);
      check("fault_idx", fault_idx, e_fidx);
      check("fault_hit", fault_hit, e_fhit);
    end
  end

  task automatic wr(int idx, bit en, logic [31:0] base, int size, int ap, bit xn, logic [7:0] srd);
    @(posedge clk); #2;
    req_valid = 0;
    cfg_we = 1; cfg_idx = 4'(idx); cfg_en = en; cfg_base = base; cfg_size = 5'(size);
    cfg_ap = 3'(ap); cfg_xn = xn; cfg_srd = srd;
  endtask

  task automatic acc(logic [31:0] a, bit w, bit f, bit p, bit t = 1, bit h = 0);
    @(posedge clk); #2;
    cfg_we = 0;
    req_valid = 1; req_addr = a; req_write = w; req_fetch = f; req_priv = p;
    req_tcm = t; req_hfctx = h;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    cfg_we = 0; req_valid = 0;
  endtask

  initial begin
    #(CLK_T*100000);
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R10";  // reset state
    check("reset fault", fault, 0);
    check("reset fault_addr", fault_addr, 0);
    check("reset allow", allow, 1);
    @(posedge clk); #2; rst_n = 1;
    ctl_en = 1;

    // R1 / R2: 4KB region 0, full access
    tag = "R1";
    wr(0, 1, 32'h2000_0000, 5'h0B, 3, 0, 8'h00);
    acc(32'h2000_0FFC, 1, 0, 0);
    tag = "R2";
    acc(32'h2000_1000, 0, 0, 1);        // just beyond span: miss -> fault
    wr(1, 1, 32'h3000_0000, 3, 3, 0, 8'h00);  // invalid size
    acc(32'h3000_0000, 0, 0, 1);
    wr(1, 1, 32'h3000_0123, 5'h04, 3, 0, 8'h00);  // 32B, base low bits ignored
    acc(32'h3000_001F, 0, 0, 0);
    acc(32'h3000_0020, 0, 0, 0);

    // R3: overlapping higher region denies
    tag = "R3";
    wr(5, 1, 32'h2000_0800, 5'h09, 0, 0, 8'h00);
    acc(32'h2000_0900, 0, 0, 1);
    acc(32'h2000_0C00, 0, 0, 1);
    // R4: disable sub-region 2 of region 5 (128B parts)
    tag = "R4";
    wr(5, 1, 32'h2000_0800, 5'h09, 0, 0, 8'h04);
    acc(32'h2000_0900, 1, 0, 0);
    acc(32'h2000_097F, 1, 0, 0);
    acc(32'h2000_0980, 1, 0, 0);
    wr(5, 0, 0, 0, 0, 0, 8'h00);

    // R5: every permission code
    tag = "R5";
    for (int ap = 0; ap < 8; ap++) begin
      wr(0, 1, 32'h2000_0000, 5'h0B, ap, 0, 8'h00);
      for (int k = 0; k < 4; k++) acc(32'h2000_0040, k[0], 0, k[1]);
      acc(32'h2000_0044, 1, 1, 0);      // fetch counts as read
    end

    // R6: execute-never
    tag = "R6";
    wr(0, 1, 32'h2000_0000, 5'h0B, 3, 1, 8'h00);
    acc(32'h2000_0100, 0, 1, 1);
    acc(32'h2000_0100, 0, 0, 1);
    acc(32'h2000_0104, 0, 1, 0);

    // R7: background map
    tag = "R7";
    ctl_privdef = 1;
    acc(32'h4000_0000, 1, 0, 1);
    acc(32'h4000_0000, 1, 0, 0);
    ctl_privdef = 0;
    acc(32'h4000_0000, 1, 0, 1);

    // R8: handler context
    tag = "R8";
    acc(32'h4000_0010, 0, 0, 0, 1, 1);
    ctl_hfnmi = 1;
    acc(32'h4000_0010, 0, 0, 0, 1, 1);
    ctl_hfnmi = 0;

    // R9: non-TCM, global off, idle
    tag = "R9";
    acc(32'h4000_0020, 1, 0, 0, 0);
    ctl_en = 0;
    acc(32'h4000_0020, 1, 0, 0);
    ctl_en = 1;
    idle();

    // R10: back-to-back faults with distinct addresses, then quiet
    tag = "R10";
    acc(32'h5000_0000, 0, 0, 0);
    acc(32'h5000_0004, 0, 0, 0);
    acc(32'h2000_0004, 0, 0, 1);
    idle();
    idle();

    // R3: random mix, writes collide with accesses
    tag = "R3";
    for (int it = 0; it < 1500; it++) begin
      if (it % 25 == 0) begin
        ctl_en = ($urandom % 8) != 0; ctl_hfnmi = $urandom; ctl_privdef = $urandom;
      end
      if ($urandom % 4 == 0) begin
        int sz = ($urandom % 16 == 0) ? int'($urandom % 4) :
                 ($urandom % 40 == 0) ? 31 : 4 + int'($urandom % 11);
        @(posedge clk); #2;
        cfg_we = 1; cfg_idx = 4'($urandom); cfg_en = ($urandom % 5) != 0;
        cfg_base = 32'h2000_0000 | ($urandom & 32'h0000_FFE0); cfg_size = 5'(sz);
        cfg_ap = 3'($urandom); cfg_xn = ($urandom % 4) == 0;
        cfg_srd = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
        req_valid = $urandom; req_addr = 32'h2000_0000 | ($urandom & 32'h0000_FFFF);
        req_write = $urandom; req_fetch = $urandom; req_priv = $urandom;
        req_tcm = ($urandom % 8) != 0; req_hfctx = ($urandom % 8) == 0;
      end else begin
        acc(32'h2000_0000 | ($urandom & 32'h0000_FFFF), 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom % 8) != 0, ($urandom % 8) == 0);
      end
    end
    idle();
    idle();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule